// File: doc/BRIEF.md
# Superframe Signaling Capture Unit

This block takes the channel-associated signaling of up to four T1/E1 trunks. The signaling arrives on its own serial TDM line, apart from the payload path. Each bit comes with a one-cycle valid strobe that has already been moved into the core clock domain. The block stores the 4-bit nibble of every channel into a per-trunk region of an on-chip signaling memory. A frame-start pulse from the external framer marks each frame. A superframe (multiframe) sync pulse, given together with a frame-start pulse, marks frame 0 of a superframe.

The block counts frames from the superframe sync. It writes to the memory only during the final frame of each superframe: frame 23 for ESF trunks and frame 15 for E1 multiframes. The memory therefore holds one consistent signaling snapshot per superframe, not a mix of frames. Two channels share a memory byte. The channel parity picks the half of the byte that is written. When the final channel of a trunk has been written, a per-trunk done pulse is raised. A superframe sync that comes at an unexpected frame count raises a one-cycle error flag, and the counter is realigned to that sync.

Top module: `cas_sf_capture`

## Requirements
- R1: After reset, `ram_we`, `cap_done` and `sync_err` are 0. No memory write occurs until the first superframe sync has been accepted.
- R2: A superframe sync counts only when it is given together with `frame_sync`. That frame is frame 0, and each later `frame_sync` advances the frame index. Writes happen only for nibbles that complete during frame 23 when `fmt_e1`=0 (ESF), or during frame 15 when `fmt_e1`=1 (E1).
- R3: Each frame carries, after `frame_sync`, 4-bit nibbles sent MSB first on `sig_data`. A bit is taken only in cycles where `sig_vld`=1. Nibbles are ordered trunk 0 channel 0 upward. A trunk has 24 channels in ESF and 32 in E1. Nibbles after the last trunk are ignored.
- R4: A write for trunk t, channel c goes to `ram_addr` = t*16 + c/2 and carries the nibble in both halves of `ram_wdata`. `ram_nib_en` is 2'b01 (low nibble) for an even c and 2'b10 (high nibble) for an odd c.
- R5: `ram_we` is high for exactly one cycle, the cycle after the clock edge that samples the fourth bit of a nibble. It is low in every other cycle.
- R6: When the unit is aligned and a superframe sync arrives while the frame that is ending is not the last frame of the current format, `sync_err` pulses for one cycle after that edge. The frame index restarts at 0.
- R7: The first superframe sync after reset, and a sync that comes right after the last frame, raise no `sync_err`.
- R8: `cap_done[t]` pulses in the same cycle as the write of trunk t's final channel (23 in ESF, 31 in E1). At most one bit is set, and only together with `ram_we`.
- R9: Without further syncs, the frame index wraps from the last frame back to 0, and a capture happens in every superframe.
- R10: `frame_sync` discards a partial nibble and restarts the bit, channel and trunk position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_e1 | input | 1 | Trunk format: 0 = ESF, 1 = E1 |
| frame_sync | input | 1 | Frame start pulse from the framer |
| sf_sync | input | 1 | Superframe sync, qualified by frame_sync |
| sig_vld | input | 1 | Signaling bit strobe |
| sig_data | input | 1 | Serial signaling bit |
| ram_we | output | 1 | Signaling memory write strobe |
| ram_addr | output | 6 | Byte address, trunk*16 + channel/2 |
| ram_wdata | output | 8 | Nibble replicated in both halves |
| ram_nib_en | output | 2 | Nibble enable, bit 0 low half, bit 1 high half |
| cap_done | output | 4 | Per-trunk capture-done pulse |
| sync_err | output | 1 | Misplaced superframe sync pulse |

## Verification
Random nibble values and random idle gaps between bits are sent through full superframes in both formats. This separates a correct bit assembly and lane choice from a write-every-frame design, because only the final frame may write. Frames sent before any sync, and a long run without a sync, show the difference between gating on alignment and free wrapping of the frame index. A sync placed early tells a real realignment apart from a silent restart. A sync at the format change, and trailing junk nibbles and partial bits, check the error qualifier and the reset of the bit position.

// File: rtl/cas_cap_pkg.sv
package cas_cap_pkg;

   typedef enum logic {
      FMT_ESF = 1'b0,
      FMT_E1  = 1'b1
   } trunk_fmt_e;

   function automatic int unsigned max_u(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned width_of(int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/cas_frame_track.sv
module cas_frame_track
   import cas_cap_pkg::*;
#(
   parameter int unsigned ESF_FRAMES = 24,
   parameter int unsigned E1_FRAMES  = 16,
   localparam int unsigned FRM_W = width_of(max_u(ESF_FRAMES, E1_FRAMES))
) (
   input  logic             clk,
   input  logic             rst_n,
   input  trunk_fmt_e       fmt,
   input  logic             frame_sync,
   input  logic             sf_sync,
   output logic             in_last,
   output logic             aligned,
   output logic             sync_err
);

   localparam logic [FRM_W-1:0] ESF_LAST = FRM_W'(ESF_FRAMES - 1);
   localparam logic [FRM_W-1:0] E1_LAST  = FRM_W'(E1_FRAMES - 1);
   localparam int unsigned      FRM_MAX  = max_u(ESF_FRAMES, E1_FRAMES);

   logic [FRM_W-1:0] frm_q;
   logic [FRM_W-1:0] last_idx;
   logic             aligned_q;
   logic             err_q;

   assign last_idx = (fmt == FMT_E1) ? E1_LAST : ESF_LAST;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frm_q     <= '0;
         aligned_q <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         err_q <= 1'b0;
         if (frame_sync) begin
            if (sf_sync) begin
               err_q     <= aligned_q && (frm_q != last_idx);
               frm_q     <= '0;
               aligned_q <= 1'b1;
            end else if (aligned_q) begin
               frm_q <= (frm_q >= last_idx) ? '0 : frm_q + 1'b1;
            end
         end
      end
   end

   assign in_last  = aligned_q && (frm_q == last_idx);
   assign aligned  = aligned_q;
   assign sync_err = err_q;

   assert_err_needs_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sync_err |-> $past(sf_sync && frame_sync));

   assert_frame_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      aligned |-> (int'(frm_q) < FRM_MAX));

   assert_sync_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_sync && sf_sync) |=> (frm_q == '0) && aligned_q);

endmodule

// File: rtl/cas_nib_deser.sv
module cas_nib_deser
   import cas_cap_pkg::*;
#(
   parameter int unsigned N_TRUNKS  = 4,
   parameter int unsigned NIB_W     = 4,
   parameter int unsigned ESF_CHANS = 24,
   parameter int unsigned E1_CHANS  = 32,
   localparam int unsigned CH_W  = width_of(max_u(ESF_CHANS, E1_CHANS)),
   localparam int unsigned TRK_W = width_of(N_TRUNKS + 1),
   localparam int unsigned BIT_W = width_of(NIB_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  trunk_fmt_e       fmt,
   input  logic             frame_sync,
   input  logic             sig_vld,
   input  logic             sig_data,
   output logic             nib_done,
   output logic [NIB_W-1:0] nib_val,
   output logic [CH_W-1:0]  nib_ch,
   output logic [TRK_W-1:0] nib_trk
);

   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(NIB_W - 1);
   localparam logic [TRK_W-1:0] TRK_END  = TRK_W'(N_TRUNKS);

   logic [NIB_W-1:0] sh_q;
   logic [BIT_W-1:0] bit_q;
   logic [CH_W-1:0]  ch_q;
   logic [TRK_W-1:0] trk_q;
   logic [CH_W-1:0]  ch_last;
   logic             word_end;
   logic             trk_live;

   assign ch_last  = (fmt == FMT_E1) ? CH_W'(E1_CHANS - 1) : CH_W'(ESF_CHANS - 1);
   assign word_end = sig_vld && !frame_sync && (bit_q == BIT_LAST);
   assign trk_live = (trk_q < TRK_END);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q  <= '0;
         bit_q <= '0;
         ch_q  <= '0;
         trk_q <= '0;
      end else if (frame_sync) begin
         sh_q  <= '0;
         bit_q <= '0;
         ch_q  <= '0;
         trk_q <= '0;
      end else if (sig_vld) begin
         sh_q <= {sh_q[NIB_W-2:0], sig_data};
         if (bit_q == BIT_LAST) begin
            bit_q <= '0;
            if (trk_live) begin
               if (ch_q >= ch_last) begin
                  ch_q  <= '0;
                  trk_q <= trk_q + 1'b1;
               end else begin
                  ch_q <= ch_q + 1'b1;
               end
            end
         end else begin
            bit_q <= bit_q + 1'b1;
         end
      end
   end

   assign nib_done = word_end && trk_live;
   assign nib_val  = {sh_q[NIB_W-2:0], sig_data};
   assign nib_ch   = ch_q;
   assign nib_trk  = trk_q;

   assert_frame_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      frame_sync |=> (bit_q == '0) && (ch_q == '0) && (trk_q == '0));

   assert_trunk_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      trk_q <= TRK_END);

endmodule

// File: rtl/cas_ram_write.sv
module cas_ram_write
   import cas_cap_pkg::*;
#(
   parameter int unsigned N_TRUNKS  = 4,
   parameter int unsigned NIB_W     = 4,
   parameter int unsigned ESF_CHANS = 24,
   parameter int unsigned E1_CHANS  = 32,
   localparam int unsigned CH_W   = width_of(max_u(ESF_CHANS, E1_CHANS)),
   localparam int unsigned TRK_W  = width_of(N_TRUNKS + 1),
   localparam int unsigned TRK_AW = (N_TRUNKS > 1) ? $clog2(N_TRUNKS) : 0,
   localparam int unsigned ADDR_W = TRK_AW + CH_W - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  trunk_fmt_e         fmt,
   input  logic               in_last,
   input  logic               nib_done,
   input  logic [NIB_W-1:0]   nib_val,
   input  logic [CH_W-1:0]    nib_ch,
   input  logic [TRK_W-1:0]   nib_trk,
   output logic               ram_we,
   output logic [ADDR_W-1:0]  ram_addr,
   output logic [2*NIB_W-1:0] ram_wdata,
   output logic [1:0]         ram_nib_en,
   output logic [N_TRUNKS-1:0] cap_done
);

   logic                wr;
   logic [ADDR_W-1:0]   addr_c;
   logic [CH_W-1:0]     ch_last;
   logic [N_TRUNKS-1:0] done_c;

   logic                we_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [2*NIB_W-1:0]  data_q;
   logic [1:0]          en_q;
   logic [N_TRUNKS-1:0] done_q;

   assign wr      = nib_done && in_last;
   assign ch_last = (fmt == FMT_E1) ? CH_W'(E1_CHANS - 1) : CH_W'(ESF_CHANS - 1);

   generate
      if (N_TRUNKS == 1) begin : g_single
         assign addr_c = nib_ch[CH_W-1:1];
      end else begin : g_multi
         assign addr_c = {nib_trk[TRK_AW-1:0], nib_ch[CH_W-1:1]};
      end
   endgenerate

   generate
      for (genvar t = 0; t < N_TRUNKS; t++) begin : g_done
         assign done_c[t] = wr && (nib_trk == TRK_W'(t)) && (nib_ch == ch_last);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         we_q   <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
         en_q   <= '0;
         done_q <= '0;
      end else begin
         we_q   <= wr;
         done_q <= done_c;
         if (wr) begin
            addr_q <= addr_c;
            data_q <= {nib_val, nib_val};
            en_q   <= nib_ch[0] ? 2'b10 : 2'b01;
         end
      end
   end

   assign ram_we     = we_q;
   assign ram_addr   = addr_q;
   assign ram_wdata  = data_q;
   assign ram_nib_en = en_q;
   assign cap_done   = done_q;

   assert_one_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> ($countones(ram_nib_en) == 1));

   assert_done_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cap_done));

   assert_done_with_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|cap_done) |-> ram_we);

   assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |=> !ram_we);

endmodule

// File: rtl/cas_sf_capture.sv
module cas_sf_capture
   import cas_cap_pkg::*;
#(
   parameter int unsigned N_TRUNKS   = 4,
   parameter int unsigned NIB_W      = 4,
   parameter int unsigned ESF_CHANS  = 24,
   parameter int unsigned E1_CHANS   = 32,
   parameter int unsigned ESF_FRAMES = 24,
   parameter int unsigned E1_FRAMES  = 16,
   localparam int unsigned CH_W   = width_of(max_u(ESF_CHANS, E1_CHANS)),
   localparam int unsigned TRK_W  = width_of(N_TRUNKS + 1),
   localparam int unsigned TRK_AW = (N_TRUNKS > 1) ? $clog2(N_TRUNKS) : 0,
   localparam int unsigned ADDR_W = TRK_AW + CH_W - 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fmt_e1,
   input  logic                frame_sync,
   input  logic                sf_sync,
   input  logic                sig_vld,
   input  logic                sig_data,
   output logic                ram_we,
   output logic [ADDR_W-1:0]   ram_addr,
   output logic [2*NIB_W-1:0]  ram_wdata,
   output logic [1:0]          ram_nib_en,
   output logic [N_TRUNKS-1:0] cap_done,
   output logic                sync_err
);

   generate
      if (N_TRUNKS < 1 || N_TRUNKS > 4) begin : g_bad_trunks
         $error("N_TRUNKS must lie in 1..4");
      end
      if (NIB_W < 2) begin : g_bad_nib
         $error("NIB_W must be at least 2");
      end
      if (ESF_CHANS < 2 || E1_CHANS < 2) begin : g_bad_chans
         $error("channel counts must be at least 2");
      end
      if (ESF_FRAMES < 2 || E1_FRAMES < 2) begin : g_bad_frames
         $error("frame counts must be at least 2");
      end
   endgenerate

   trunk_fmt_e       fmt;
   logic             in_last;
   logic             aligned;
   logic             nib_done;
   logic [NIB_W-1:0] nib_val;
   logic [CH_W-1:0]  nib_ch;
   logic [TRK_W-1:0] nib_trk;

   assign fmt = trunk_fmt_e'(fmt_e1);

   cas_frame_track #(
      .ESF_FRAMES (ESF_FRAMES),
      .E1_FRAMES  (E1_FRAMES)
   ) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .fmt        (fmt),
      .frame_sync (frame_sync),
      .sf_sync    (sf_sync),
      .in_last    (in_last),
      .aligned    (aligned),
      .sync_err   (sync_err)
   );

   cas_nib_deser #(
      .N_TRUNKS  (N_TRUNKS),
      .NIB_W     (NIB_W),
      .ESF_CHANS (ESF_CHANS),
      .E1_CHANS  (E1_CHANS)
   ) u_deser (
      .clk        (clk),
      .rst_n      (rst_n),
      .fmt        (fmt),
      .frame_sync (frame_sync),
      .sig_vld    (sig_vld),
      .sig_data   (sig_data),
      .nib_done   (nib_done),
      .nib_val    (nib_val),
      .nib_ch     (nib_ch),
      .nib_trk    (nib_trk)
   );

   cas_ram_write #(
      .N_TRUNKS  (N_TRUNKS),
      .NIB_W     (NIB_W),
      .ESF_CHANS (ESF_CHANS),
      .E1_CHANS  (E1_CHANS)
   ) u_write (
      .clk        (clk),
      .rst_n      (rst_n),
      .fmt        (fmt),
      .in_last    (in_last),
      .nib_done   (nib_done),
      .nib_val    (nib_val),
      .nib_ch     (nib_ch),
      .nib_trk    (nib_trk),
      .ram_we     (ram_we),
      .ram_addr   (ram_addr),
      .ram_wdata  (ram_wdata),
      .ram_nib_en (ram_nib_en),
      .cap_done   (cap_done)
   );

   assert_no_write_unaligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> aligned);

   assert_addr_in_region_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (int'(ram_addr) < N_TRUNKS * (1 << (CH_W - 1))));

   assert_err_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sync_err |-> !ram_we);

endmodule

// File: tb/sim_cas_sf_capture.sv
module sim_cas_sf_capture;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       fmt_e1;
   logic       frame_sync;
   logic       sf_sync;
   logic       sig_vld;
   logic       sig_data;
   logic       ram_we;
   logic [5:0] ram_addr;
   logic [7:0] ram_wdata;
   logic [1:0] ram_nib_en;
   logic [3:0] cap_done;
   logic       sync_err;

   int n_chk = 0;
   int n_err = 0;
   int n_wr  = 0;

   bit m_aligned = 0;
   int m_fidx    = 0;
   bit m_e1      = 0;

   always #2 clk = ~clk;

   cas_sf_capture u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .fmt_e1     (fmt_e1),
      .frame_sync (frame_sync),
      .sf_sync    (sf_sync),
      .sig_vld    (sig_vld),
      .sig_data   (sig_data),
      .ram_we     (ram_we),
      .ram_addr   (ram_addr),
      .ram_wdata  (ram_wdata),
      .ram_nib_en (ram_nib_en),
      .cap_done   (cap_done),
      .sync_err   (sync_err)
   );

   function automatic int last_of(bit e1);
      return e1 ? 15 : 23;
   endfunction

   function automatic int chans_of(bit e1);
      return e1 ? 32 : 24;
   endfunction

   function automatic int exp_addr(int trk, int ch);
      return trk * 16 + ch / 2;
   endfunction

   function automatic logic [1:0] exp_en(int ch);
      return (ch % 2 == 1) ? 2'b10 : 2'b01;
   endfunction

   task automatic chk(string req, bit ok, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(bit v, bit d, bit fs, bit sf);
      sig_vld    = v;
      sig_data   = d;
      frame_sync = fs;
      sf_sync    = sf;
      @(negedge clk);
   endtask

   task automatic send_nibble(int trk, int ch, logic [3:0] nib, bit inl);
      bit ew;
      for (int b = 3; b >= 0; b--) begin
         if ($urandom % 4 == 0) begin
            step(0, 0, 0, 0);
            chk("R5 idle no write", ram_we == 1'b0, ram_we, 0);
         end
         step(1, nib[b], 0, 0);
         if (b != 0) chk("R5 mid-nibble no write", ram_we == 1'b0, ram_we, 0);
      end
      ew = inl && (trk < 4);
      chk("R2 write gating", ram_we == ew, ram_we, ew);
      if (ew && ram_we) begin
         n_wr++;
         chk("R4 address", ram_addr == 6'(exp_addr(trk, ch)), ram_addr, exp_addr(trk, ch));
         chk("R3 nibble data", ram_wdata == {nib, nib}, ram_wdata, {nib, nib});
         chk("R4 lane enable", ram_nib_en == exp_en(ch), ram_nib_en, exp_en(ch));
      end
      if (ew && ch == chans_of(m_e1) - 1)
         chk("R8 capture done", cap_done == 4'(1 << trk), cap_done, 1 << trk);
      else
         chk("R8 no done", cap_done == 4'b0, cap_done, 0);
   endtask

   task automatic run_frame(bit sf, bit new_e1, bit junk);
      bit eerr;
      bit inl;
      eerr = sf && m_aligned && (m_fidx != last_of(m_e1));
      if (sf) begin
         m_fidx    = 0;
         m_aligned = 1;
      end else if (m_aligned) begin
         m_fidx = (m_fidx >= last_of(m_e1)) ? 0 : m_fidx + 1;
      end
      step(0, 0, 1, sf);
      chk(eerr ? "R6 sync error" : "R7 no sync error", sync_err == eerr, sync_err, eerr);
      fmt_e1 = new_e1;
      m_e1   = new_e1;
      inl    = m_aligned && (m_fidx == last_of(m_e1));
      for (int t = 0; t < 4; t++)
         for (int c = 0; c < chans_of(m_e1); c++)
            send_nibble(t, c, 4'($urandom), inl);
      if (junk) begin
         send_nibble(4, 0, 4'($urandom), inl);
         step(1, 1, 0, 0);
         chk("R10 partial no write", ram_we == 1'b0, ram_we, 0);
         step(1, 0, 0, 0);
         chk("R10 partial no write", ram_we == 1'b0, ram_we, 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      int wr_before;
      void'($urandom(32'd1357));
      rst_n = 0; fmt_e1 = 0; frame_sync = 0; sf_sync = 0; sig_vld = 0; sig_data = 0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 reset ram_we", ram_we == 1'b0, ram_we, 0);
      chk("R1 reset done", cap_done == 4'b0, cap_done, 0);
      chk("R1 reset sync_err", sync_err == 1'b0, sync_err, 0);

      // R1: frames before any sync must not write
      for (int f = 0; f < 2; f++) run_frame(0, 0, 1);

      // R2 R7: first superframe in ESF, sync accepted without error
      run_frame(1, 0, 0);
      for (int f = 1; f < 24; f++) run_frame(0, 0, f % 3 == 0);
      chk("R2 ESF snapshot size", n_wr == 96, n_wr, 96);

      // R9: no further sync, capture repeats on the wrapped index
      wr_before = n_wr;
      for (int f = 0; f < 24; f++) run_frame(0, 0, f % 2 == 0);
      chk("R9 wrapped capture", n_wr - wr_before == 96, n_wr - wr_before, 96);

      // R7: sync right after the last ESF frame, switching to E1
      wr_before = n_wr;
      run_frame(1, 1, 0);
      for (int f = 1; f < 16; f++) run_frame(0, 1, f % 4 == 1);
      chk("R3 E1 snapshot size", n_wr - wr_before == 128, n_wr - wr_before, 128);

      // R6: early sync realigns the count
      for (int f = 0; f < 5; f++) run_frame(0, 1, 1);
      wr_before = n_wr;
      run_frame(1, 1, 1);
      for (int f = 1; f < 16; f++) run_frame(0, 1, 0);
      chk("R6 realigned capture", n_wr - wr_before == 128, n_wr - wr_before, 128);

      step(0, 0, 0, 0);
      chk("R5 quiet after run", ram_we == 1'b0, ram_we, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule